// File: doc/BRIEF.md
# Programmable Threshold Offset Loader

This block holds the two thresholds that a synchronous FIFO's almost-empty and almost-full flag logic compares against. Each threshold is 13 bits wide, but the block is loaded over an 8-bit data bus, so each threshold is split into a low byte register and a high register. That makes four registers in all. There are no address lines. While the load control is low, every write-clock edge with the write enable asserted stores the bus into the register the write index points at, then moves the index on. Every read-clock edge with both read enables asserted returns the register the read index points at, then moves that index on. Both indices visit the registers in the same fixed cyclic order.

With the load control high, the block ignores the write and read enables, and the FIFO can run normally. The two assembled thresholds are always present on dedicated outputs for the flag logic. The write index and the read index are separate registers, and each one is clocked in its own domain.

Top module: `ofs_loader`

## Requirements
- R1: While reset is asserted and after it is released, both threshold outputs equal 7, the readback output equals 0, and both indices point to index 0.
- R2: A write fires when load_n=0 and wen_n=0. Successive writes fill the registers in the order index 0 (empty low byte), 1 (empty high), 2 (full low byte), 3 (full high). After index 3 the index wraps to 0.
- R3: A low-byte register supplies threshold bits 7:0 from din[7:0]. A high register supplies threshold bits 12:8 from din[4:0], and din[7:5] are discarded.
- R4: A read fires when load_n=0, ren_a_n=0, ren_b_n=0 and wen_n=1. At that clock edge dout takes the register at the read index, and the read index then advances in the same cyclic order as writes.
- R5: A read of a high register returns zero in dout[7:5].
- R6: With load_n=1, the write, read and data inputs change neither register contents, nor either index, nor dout.
- R7: With load_n=0 and wen_n=1, and without both read enables low, nothing changes.
- R8: If only one of the two read enables is low, no read fires.
- R9: If a write and a read are requested in the same cycle, the write is performed and the read is ignored: dout and the read index hold.
- R10: Taking load_n high in the middle of a sequence does not move either index. A later session continues from the register where the earlier one stopped.
- R11: Writes never move the read index, and reads never move the write index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Offset access select, active low |
| wen_n | input | 1 | Write enable, active low |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| din | input | 8 | Write data bus |
| dout | output | 8 | Register readback |
| empty_ofs | output | 13 | Assembled almost-empty threshold |
| full_ofs | output | 13 | Assembled almost-full threshold |

## Verification
The assertions on the read side sample wen_n on the read clock. This relies on the write enable being stable at read-clock edges, which holds when both clocks are tied together, as they are in the bench. The stimulus changes every input only on the falling edge, so no control input moves near an active edge. The sweep covers all 256 bus values in every register, and it also covers every combination of load, write and read enable that matters here, including the collision of a write with a read.

// File: rtl/ofs_loader.sv
module ofs_loader #(
  parameter int BUS_W   = 8,
  parameter int OFS_W   = 13,
  parameter int DEF_OFS = 7
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             wen_n,
  input  logic             ren_a_n,
  input  logic             ren_b_n,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] dout,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs
);
  localparam int HI_W = OFS_W - BUS_W;
  localparam logic [OFS_W-1:0] DEF_V = OFS_W'(DEF_OFS);

  logic [1:0]       wr_idx, rd_idx;
  logic [BUS_W-1:0] lo_e, lo_f;
  logic [HI_W-1:0]  hi_e, hi_f;
  logic [BUS_W-1:0] rd_sel;

  wire wr_fire = !load_n && !wen_n;
  wire rd_fire = !load_n && !ren_a_n && !ren_b_n && wen_n;

  assign empty_ofs = {hi_e, lo_e};
  assign full_ofs  = {hi_f, lo_f};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= 2'd0;
      lo_e   <= DEF_V[BUS_W-1:0];
      hi_e   <= DEF_V[OFS_W-1:BUS_W];
      lo_f   <= DEF_V[BUS_W-1:0];
      hi_f   <= DEF_V[OFS_W-1:BUS_W];
    end else if (wr_fire) begin
      wr_idx <= wr_idx + 2'd1;
      case (wr_idx)
        2'd0: lo_e <= din;
        2'd1: hi_e <= din[HI_W-1:0];
        2'd2: lo_f <= din;
        default: hi_f <= din[HI_W-1:0];
      endcase
    end
  end

  always_comb begin
    case (rd_idx)
      2'd0: rd_sel = lo_e;
      2'd1: rd_sel = {{(BUS_W-HI_W){1'b0}}, hi_e};
      2'd2: rd_sel = lo_f;
      default: rd_sel = {{(BUS_W-HI_W){1'b0}}, hi_f};
    endcase
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= 2'd0;
      dout   <= '0;
    end else if (rd_fire) begin
      rd_idx <= rd_idx + 2'd1;
      dout   <= rd_sel;
    end
  end

  a_r2_wr_advance: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_fire |=> wr_idx == 2'($past(wr_idx) + 2'd1));
  a_r3_hi_e_mask: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_fire && wr_idx == 2'd1) |=> hi_e == $past(din[HI_W-1:0]));
  a_r6_idle_load_high: assert property (@(posedge wclk) disable iff (!rst_n)
    load_n |=> ($stable(wr_idx) && $stable(empty_ofs) && $stable(full_ofs)));
  a_r4_rd_advance: assert property (@(posedge rclk) disable iff (!rst_n)
    rd_fire |=> rd_idx == 2'($past(rd_idx) + 2'd1));
  a_r5_hi_zero: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_fire && rd_idx[0]) |=> dout[BUS_W-1:HI_W] == '0);
  a_r9_write_wins: assert property (@(posedge rclk) disable iff (!rst_n)
    (!load_n && !wen_n) |=> ($stable(rd_idx) && $stable(dout)));
endmodule

// File: tb/ofs_loader_tb.sv
module ofs_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n, load_n, wen_n, ren_a_n, ren_b_n;
  logic [7:0]  din, dout;
  logic [12:0] empty_ofs, full_ofs;
  int tests = 0, fails = 0;

  logic [7:0] m [4];
  logic [1:0] wi, ri;
  logic [7:0] md;

  always #2 clk = ~clk;

  ofs_loader dut_i (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .din(din), .dout(dout),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, {19'd0, empty_ofs}, {19'd0, m[1][4:0], m[0]});
    chk(tag, {19'd0, full_ofs},  {19'd0, m[3][4:0], m[2]});
    chk(tag, {24'd0, dout}, {24'd0, md});
  endtask

  task automatic op(string tag, logic l, logic w, logic a, logic b, logic [7:0] d);
    load_n = l; wen_n = w; ren_a_n = a; ren_b_n = b; din = d;
    @(posedge clk);
    if (!l && !w) begin
      m[wi] = wi[0] ? {3'b000, d[4:0]} : d;
      wi = wi + 2'd1;
    end else if (!l && !a && !b) begin
      md = m[ri];
      ri = ri + 2'd1;
    end
    @(negedge clk);
    check_all(tag);
    load_n = 1'b1; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1; din = '0;
    m[0] = 8'd7; m[1] = 8'd0; m[2] = 8'd7; m[3] = 8'd0; wi = 0; ri = 0; md = 0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");
    for (int i = 0; i < 8; i++) op("R4 R5 default readback", 0, 1, 0, 0, 8'hFF);
    for (int v = 0; v < 256; v++) begin
      op("R2 R3 write sweep", 0, 0, 1, 1, 8'(v));
      op("R2 R3 write sweep", 0, 0, 1, 1, 8'(v) ^ 8'h5A);
      op("R2 R3 write sweep", 0, 0, 1, 1, ~8'(v));
      op("R2 R3 write sweep", 0, 0, 1, 1, 8'(v + 1));
      for (int k = 0; k < 4; k++) op("R4 R5 readback sweep", 0, 1, 0, 0, 8'(v));
    end
    for (int c = 0; c < 16; c++)
      op("R6 load high ignores", 1, c[0], c[1], c[2], 8'(c * 17));
    op("R7 no op", 0, 1, 1, 1, 8'h33);
    op("R8 single ren a", 0, 1, 0, 1, 8'h44);
    op("R8 single ren b", 0, 1, 1, 0, 8'h55);
    op("R9 write wins", 0, 0, 0, 0, 8'hC3);
    op("R9 write wins", 0, 0, 0, 0, 8'h9E);
    op("R11 read after collisions", 0, 1, 0, 0, 8'h00);
    op("R10 partial session", 0, 0, 1, 1, 8'hA1);
    op("R10 load high gap", 1, 0, 0, 0, 8'h00);
    op("R10 resumed session", 0, 0, 1, 1, 8'hB2);
    op("R10 resumed session", 0, 0, 1, 1, 8'hC4);
    for (int k = 0; k < 5; k++) op("R10 R11 readback", 0, 1, 0, 0, 8'h00);
    op("R11 write keeps read index", 0, 0, 1, 1, 8'h6D);
    op("R11 read order", 0, 1, 0, 0, 8'h00);
    rst_n = 1'b0;
    m[0] = 8'd7; m[1] = 8'd0; m[2] = 8'd7; m[3] = 8'd0; wi = 0; ri = 0; md = 0;
    @(negedge clk);
    check_all("R1 second reset");
    rst_n = 1'b1;
    @(negedge clk);
    op("R1 R4 index back at 0", 0, 1, 0, 0, 8'h00);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule